// File: doc/BRIEF.md
# H-bridge PWM mode controller

This block converts a direction and duty request into raw on/off requests for the four switches of a full bridge: a left leg and a right leg, each with a high-side and a low-side switch. A free-running tick counter sets the PWM period. In sign-magnitude mode one leg is held in a fixed state and the other leg is pulsed. In lock anti-phase mode both legs are pulsed with complementary waveforms, so the duty alone sets both speed and direction. Explicit brake and coast requests override the PWM output.

Duty is a fraction of 2^DW. It is clamped to a maximum high-side share so that the high-side gate supply can recover. Every pulsed low side is also guaranteed a minimum on-time in each period, so that the bootstrap capacitor can recharge. In anti-phase mode, a narrow band of duties around one half produces a brake instead of a buzzing zero-average waveform. Mode, direction, duty and period are sampled only at a period boundary. Dead-time insertion is left to a later stage.

Top module: `hbridge_pwm`

## Requirements
- R1: While reset is asserted, all four gate outputs are 0. When `en` is sampled low at a clock edge, all four gate outputs are 0 after that edge.
- R2: The high side and the low side of the same leg are never on in the same cycle.
- R3: When `coast_req` is sampled high at an edge, all four outputs are 0 after that edge. This holds whatever the state of `brake_req` and of the PWM.
- R4: When `brake_req` is sampled high with `en` high and `coast_req` low, the outputs after that edge are: both low sides on, both high sides off.
- R5: In sign-magnitude forward (`mode_lap`=0, `dir_rev`=0), the right low side is held on and the right high side is held off. Over one period, the left high side is on for the first H ticks and the left low side is on for the rest.
- R6: In sign-magnitude reverse (`mode_lap`=0, `dir_rev`=1), the left low side is held on and the left high side is held off. Over one period, the right high side is on for the first H ticks and the right low side is on for the rest.
- R7: In lock anti-phase mode (`mode_lap`=1), the left high side and the right low side are on for the first H ticks of the period. The left low side and the right high side are on for the remaining ticks. `dir_rev` has no effect in this mode. A duty above one half therefore drives forward, and a duty below one half drives reverse.
- R8: In lock anti-phase mode, a duty value between BAND_LO and BAND_HI inclusive (default 126 to 130 of 256) produces the brake pattern for the whole period.
- R9: The duty used to compute H is limited to at most MAX_DUTY/256 (default 243, about 95 %; legal up to 248, about 97 %). In anti-phase mode it is also limited to at least (256-MAX_DUTY)/256.
- R10: H never exceeds period-MIN_LO, so a pulsed low side is on for at least MIN_LO ticks per period. In anti-phase mode, H is also at least MIN_LO.
- R11: Mode, direction, duty and period are latched at the start of a period. Changing them mid-period does not alter the current period.
- R12: H = floor(duty_limited × period / 256), where `period` is the period length in clock ticks. Outputs are registered: the tick with counter value j appears one cycle after that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; low forces coast |
| mode_lap | input | 1 | 1 = lock anti-phase, 0 = sign-magnitude |
| dir_rev | input | 1 | 1 = reverse, 0 = forward (sign-magnitude only) |
| duty | input | DW | Duty as a fraction of 2^DW |
| period | input | CW | PWM period length in ticks |
| brake_req | input | 1 | Request both low sides on |
| coast_req | input | 1 | Request all switches off; beats brake |
| gate_lh | output | 1 | Left high-side switch request |
| gate_ll | output | 1 | Left low-side switch request |
| gate_rh | output | 1 | Right high-side switch request |
| gate_rl | output | 1 | Right low-side switch request |

## Verification
Two functions can land in the same cycle: the period-boundary latch of a new mode and duty, and an override request (brake or coast) that is sampled at that same edge. The bench applies each new configuration together with its override at the negative edge just before the boundary. It then checks every tick of the following period against a pattern computed from the requirements, so a stale latch or a late override shows up at the first tick. Boundary overlaps of the limits are provoked as well. The maximum-duty limit and the minimum low-side time are run at two period lengths, so that each limit binds on its own in one case. A dead-band duty is combined with a brake request to confirm that both give the same pattern.

// File: rtl/hbridge_pwm.sv
module hbridge_pwm #(
  parameter int CW       = 12,
  parameter int DW       = 8,
  parameter int MAX_DUTY = 243,
  parameter int BAND_LO  = 126,
  parameter int BAND_HI  = 130,
  parameter int MIN_LO   = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode_lap,
  input  logic          dir_rev,
  input  logic [DW-1:0] duty,
  input  logic [CW-1:0] period,
  input  logic          brake_req,
  input  logic          coast_req,
  output logic          gate_lh,
  output logic          gate_ll,
  output logic          gate_rh,
  output logic          gate_rl
);
  localparam logic [DW-1:0] DMAX = DW'(MAX_DUTY);
  localparam logic [DW-1:0] DMIN = DW'((1 << DW) - MAX_DUTY);
  localparam logic [DW-1:0] BLO  = DW'(BAND_LO);
  localparam logic [DW-1:0] BHI  = DW'(BAND_HI);
  localparam logic [CW-1:0] LO   = CW'(MIN_LO);

  logic [CW-1:0]    cnt, p_per, raw, top, t1, hi;
  logic [DW-1:0]    p_duty, d_hi, d_c;
  logic [DW+CW-1:0] prod;
  logic             p_mode, p_dir, wrap, pulse, in_band;
  logic [3:0]       nxt, gates;

  assign wrap = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, p_per};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      p_per  <= '0;
      p_duty <= '0;
      p_mode <= 1'b0;
      p_dir  <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      p_per  <= period;
      p_duty <= duty;
      p_mode <= mode_lap;
      p_dir  <= dir_rev;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign d_hi    = (p_duty > DMAX) ? DMAX : p_duty;
  assign d_c     = (p_mode && d_hi < DMIN) ? DMIN : d_hi;
  assign prod    = {{CW{1'b0}}, d_c} * {{DW{1'b0}}, p_per};
  assign raw     = prod[DW+CW-1:DW];
  assign top     = (p_per > LO) ? p_per - LO : '0;
  assign t1      = (p_mode && raw < LO) ? LO : raw;
  assign hi      = (t1 > top) ? top : t1;
  assign pulse   = cnt < hi;
  assign in_band = p_mode && p_duty >= BLO && p_duty <= BHI;

  always_comb begin
    if (!en || coast_req)        nxt = 4'b0000;
    else if (brake_req || in_band) nxt = 4'b0101;
    else if (p_mode)             nxt = {pulse, !pulse, !pulse, pulse};
    else if (!p_dir)             nxt = {pulse, !pulse, 1'b0, 1'b1};
    else                         nxt = {1'b0, 1'b1, pulse, !pulse};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gates <= 4'b0000;
    else        gates <= nxt;
  end

  assign {gate_lh, gate_ll, gate_rh, gate_rl} = gates;
endmodule

// File: rtl/hbridge_pwm_chk.sv
module hbridge_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic brake_req,
  input logic coast_req,
  input logic gate_lh,
  input logic gate_ll,
  input logic gate_rh,
  input logic gate_rl
);
  assert_left_leg_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lh && gate_ll));

  assert_right_leg_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_rh && gate_rl));

  assert_disable_coasts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(gate_lh || gate_ll || gate_rh || gate_rl));

  assert_coast_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    coast_req |=> !(gate_lh || gate_ll || gate_rh || gate_rl));

  assert_brake_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !coast_req && brake_req) |=> (gate_ll && gate_rl && !gate_lh && !gate_rh));
endmodule

bind hbridge_pwm hbridge_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .brake_req(brake_req), .coast_req(coast_req),
  .gate_lh(gate_lh), .gate_ll(gate_ll), .gate_rh(gate_rh), .gate_rl(gate_rl)
);

// File: tb/hbridge_pwm_tb.sv
`timescale 1ns/1ps
module hbridge_pwm_tb;
  localparam int CW = 8, DW = 8, MAXD = 243, BLO = 126, BHI = 130, MINLO = 4;

  logic clk, rst_n, en, mode_lap, dir_rev, brake_req, coast_req;
  logic [DW-1:0] duty;
  logic [CW-1:0] period;
  logic gate_lh, gate_ll, gate_rh, gate_rl;

  hbridge_pwm #(.CW(CW), .DW(DW), .MAX_DUTY(MAXD), .BAND_LO(BLO), .BAND_HI(BHI), .MIN_LO(MINLO)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_lap(mode_lap), .dir_rev(dir_rev),
    .duty(duty), .period(period), .brake_req(brake_req), .coast_req(coast_req),
    .gate_lh(gate_lh), .gate_ll(gate_ll), .gate_rh(gate_rh), .gate_rl(gate_rl));

  typedef struct {
    int         edge_no;
    logic [3:0] pat;
    string      tag;
  } item_t;

  item_t q[$];
  int ecnt, P, errors, checks;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  function automatic logic [3:0] expect_pat(bit lap, bit rev, int d, bit brk, bit cst, bit ena, int j, int per);
    int dc, h, top;
    logic p;
    if (!ena || cst) return 4'b0000;
    if (brk) return 4'b0101;
    if (lap && d >= BLO && d <= BHI) return 4'b0101;
    dc = (d > MAXD) ? MAXD : d;
    if (lap && dc < 256 - MAXD) dc = 256 - MAXD;
    h = (dc * per) / 256;
    if (lap && h < MINLO) h = MINLO;
    top = (per > MINLO) ? per - MINLO : 0;
    if (h > top) h = top;
    p = (j < h);
    if (lap)       return {p, ~p, ~p, p};
    else if (!rev) return {p, ~p, 1'b0, 1'b1};
    else           return {1'b0, 1'b1, p, ~p};
  endfunction

  task automatic run_period(input bit lap, input bit rev, input int d, input bit brk,
                            input bit cst, input bit ena, input string tag);
    do @(negedge clk); while (ecnt % P != 0);
    mode_lap = lap; dir_rev = rev; duty = DW'(d);
    brake_req = brk; coast_req = cst; en = ena;
    for (int j = 0; j < P - 1; j++) begin
      item_t it;
      it.edge_no = ecnt + 2 + j;
      it.pat = expect_pat(lap, rev, d, brk, cst, ena, j, P);
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic do_reset(input int per);
    repeat (P + 5) @(negedge clk);
    rst_n = 1'b0; en = 1'b0; brake_req = 1'b0; coast_req = 1'b0;
    mode_lap = 1'b0; dir_rev = 1'b0; duty = '0;
    period = CW'(per); P = per;
    @(negedge clk);
    checks++;
    if ({gate_lh, gate_ll, gate_rh, gate_rl} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: got %b expected 0000", {gate_lh, gate_ll, gate_rh, gate_rl});
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].edge_no == ecnt) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({gate_lh, gate_ll, gate_rh, gate_rl} !== it.pat) begin
        errors++;
        $display("FAIL %s: got %b expected %b at edge %0d", it.tag,
                 {gate_lh, gate_ll, gate_rh, gate_rl}, it.pat, it.edge_no);
      end
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0; P = 100; rst_n = 1'b0;
    do_reset(100);
    run_period(0, 0, 64, 0, 0, 0, "R1 enable low");
    run_period(0, 0, 64, 0, 0, 1, "R5 R12 sm fwd 64");
    run_period(0, 0, 200, 0, 0, 1, "R5 R12 sm fwd 200");
    run_period(0, 1, 64, 0, 0, 1, "R6 sm rev 64");
    run_period(0, 0, 0, 0, 0, 1, "R5 sm fwd 0");
    run_period(0, 0, 255, 0, 0, 1, "R9 sm fwd max clamp");
    run_period(1, 0, 200, 0, 0, 1, "R7 lap 200");
    run_period(1, 1, 200, 0, 0, 1, "R7 lap dir ignored");
    run_period(1, 0, 64, 0, 0, 1, "R7 lap 64");
    run_period(1, 0, 128, 0, 0, 1, "R8 band center");
    run_period(1, 0, 126, 0, 0, 1, "R8 band low edge");
    run_period(1, 0, 131, 0, 0, 1, "R8 just above band");
    run_period(1, 0, 10, 0, 0, 1, "R9 lap low clamp");
    run_period(1, 0, 200, 1, 0, 1, "R4 brake over lap");
    run_period(1, 0, 128, 1, 0, 1, "R4 R8 brake in band");
    run_period(0, 1, 64, 1, 1, 1, "R3 coast over brake");
    run_period(0, 0, 64, 0, 0, 1, "R11 before change");
    repeat (5) @(negedge clk);
    duty = 8'd255; mode_lap = 1'b1; dir_rev = 1'b1;
    run_period(0, 1, 200, 0, 0, 1, "R11 after change");
    do_reset(40);
    run_period(0, 0, 255, 0, 0, 1, "R10 sm fwd min low");
    run_period(0, 1, 255, 0, 0, 1, "R10 sm rev min low");
    run_period(1, 0, 0, 0, 0, 1, "R10 lap min low");
    run_period(1, 0, 255, 0, 0, 1, "R10 lap top");
    repeat (P + 5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule